// File: doc/BRIEF.md
# MSI Doorbell Device-ID Tagging Bridge

This block stands between the agents that raise message-signalled interrupts and the doorbell register of an interrupt translation unit. Each agent writes its event number to its own 32-bit slot in an aliasing window. The bridge works out which slot was written, turns that slot number into a device ID, and sends one doorbell write that carries both the event number and the device ID. The agent never drives a device ID of its own: the ID comes only from the address. A 32-bit write to the doorbell register address itself is also forwarded, and it carries device ID zero.

Software places the window with a base address and a window exponent. The window exponent is the number of device-ID bits requested, so the window spans four bytes times two to that power. The doorbell unit may accept fewer ID bits than the window requests. In that case the bridge narrows the window to the ID width the unit supports. A write is dropped, and a one-cycle error pulse is raised, if it has the wrong size, is misaligned, or hits neither the window nor the doorbell address. The output stage is a single register slot with valid/ready flow control.

Top module: `msi_devid_bridge`

## Requirements
- R1: With exponent E = min(cfg_win_bits, ID_W, MAX_WIN_BITS), the window covers the 4<<E bytes that start at cfg_win_base. The base is assumed aligned to that span.
- R2: A valid window write is forwarded with db_devid equal to bits [E+1:2] of (req_addr - cfg_win_base). Higher devid bits are zero.
- R3: db_data equals the req_data of the accepted write, unchanged.
- R4: A valid write to cfg_db_addr is forwarded with db_devid = 0. This match takes priority over a window hit at the same address.
- R5: If cfg_win_bits exceeds ID_W, the span narrows to 4<<ID_W. A write above that span, even if it lies inside the configured window, is rejected as a miss.
- R6: req_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Only size 2 with req_addr[1:0] = 0 is valid. Any other write to the window or to the doorbell is dropped with an error pulse.
- R7: A write that hits neither the window nor the doorbell address is not forwarded and raises the error pulse.
- R8: req_ready is high only when the output slot is empty or db_ready is high. While db_valid is high and db_ready is low, db_data and db_devid hold steady, so no write is lost.
- R9: During and right after reset, db_valid and req_err are low.
- R10: req_err goes high for exactly the one cycle after a dropped write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_base | input | ADDR_W | Window base address |
| cfg_win_bits | input | WB_W | Requested number of device-ID bits (window exponent) |
| cfg_db_addr | input | ADDR_W | Address of the doorbell register |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Write request accepted this cycle |
| req_addr | input | ADDR_W | Write byte address |
| req_data | input | DATA_W | Write data (event number) |
| req_size | input | 2 | Write size code |
| req_err | output | 1 | Pulse: previous accepted write was dropped |
| db_valid | output | 1 | Doorbell write valid |
| db_ready | input | 1 | Doorbell unit can take the write |
| db_data | output | DATA_W | Event number to the doorbell |
| db_devid | output | ID_W | Device ID to the doorbell |

## Verification
The hardest case to reach from the ports is a write that lies inside the configured window but above the narrowed span. It only shows up when the requested exponent is larger than the translator ID width. The bench sets the exponent above ID_W and then writes to the last valid slot and to the first address past it. A second difficult case is an overlap between the doorbell address and the window. The bench moves the doorbell address into the window to show that the direct-doorbell match wins. To cover the backpressure hold, the bench keeps db_ready low while a second request waits, and then releases both in the same cycle.

// File: rtl/msi_bridge_pkg.sv
package msi_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } req_size_e;

    typedef enum logic [1:0] {
        HIT_NONE     = 2'd0,
        HIT_DOORBELL = 2'd1,
        HIT_WINDOW   = 2'd2,
        HIT_BADFMT   = 2'd3
    } hit_kind_e;

endpackage

// File: rtl/msi_win_decode.sv
module msi_win_decode
    import msi_bridge_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int ID_W         = 8,
    parameter int MAX_WIN_BITS = 16,
    parameter int WB_W         = $clog2(MAX_WIN_BITS + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] cfg_win_base,
    input  logic [WB_W-1:0]   cfg_win_bits,
    input  logic [ADDR_W-1:0] cfg_db_addr,
    output hit_kind_e         kind,
    output logic [ID_W-1:0]   devid,
    output logic [WB_W-1:0]   eff_bits
);

    localparam int              LIM   = (ID_W < MAX_WIN_BITS) ? ID_W : MAX_WIN_BITS;
    localparam logic [WB_W-1:0] LIM_W = WB_W'(LIM);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] span_mask;
    logic              in_window;
    logic              fmt_ok;
    logic [ID_W-1:0]   slot_id;

    // effective exponent: narrowest of request, translator width, hardware limit
    always_comb begin
        eff_bits = (cfg_win_bits > LIM_W) ? LIM_W : cfg_win_bits;
    end

    always_comb begin
        offset = addr - cfg_win_base;
        for (int i = 0; i < ADDR_W; i++) begin
            span_mask[i] = (i < int'(eff_bits) + 2);
        end
        in_window = ((offset & ~span_mask) == '0);
        for (int i = 0; i < ID_W; i++) begin
            slot_id[i] = offset[i+2] && (i < int'(eff_bits));
        end
        fmt_ok = (size == SZ_WORD) && (addr[1:0] == 2'b00);
    end

    // doorbell match is checked first so it wins over an overlapping window
    always_comb begin
        kind  = HIT_NONE;
        devid = '0;
        if (addr == cfg_db_addr) begin
            kind = fmt_ok ? HIT_DOORBELL : HIT_BADFMT;
        end else if (in_window) begin
            kind  = fmt_ok ? HIT_WINDOW : HIT_BADFMT;
            devid = slot_id;
        end
    end

endmodule

// File: rtl/msi_out_stage.sv
module msi_out_stage #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              drop,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ID_W-1:0]   in_devid,
    input  logic              out_ready,
    output logic              can_accept,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [ID_W-1:0]   out_devid,
    output logic              err
);

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
        logic [ID_W-1:0]   devid;
    } slot_t;

    slot_t slot_d, slot_q;

    assign can_accept = !slot_q.valid || out_ready;

    always_comb begin
        slot_d     = slot_q;
        slot_d.err = drop;
        if (slot_q.valid && out_ready) begin
            slot_d.valid = 1'b0;
        end
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.data  = in_data;
            slot_d.devid = in_devid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_valid = slot_q.valid;
    assign out_data  = slot_q.data;
    assign out_devid = slot_q.devid;
    assign err       = slot_q.err;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_devid))
        else $error("p_hold_r8: stalled doorbell write changed");

endmodule

// File: rtl/msi_devid_bridge.sv
module msi_devid_bridge
    import msi_bridge_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int ID_W         = 8,
    parameter int MAX_WIN_BITS = 16,
    parameter int WB_W         = $clog2(MAX_WIN_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_win_base,
    input  logic [WB_W-1:0]   cfg_win_bits,
    input  logic [ADDR_W-1:0] cfg_db_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_size,
    output logic              req_err,
    output logic              db_valid,
    input  logic              db_ready,
    output logic [DATA_W-1:0] db_data,
    output logic [ID_W-1:0]   db_devid
);

    hit_kind_e         kind;
    logic [ID_W-1:0]   dec_devid;
    logic [WB_W-1:0]   eff_bits;
    logic              accept;
    logic              fwd;
    logic              drop;

    msi_win_decode #(
        .ADDR_W       (ADDR_W),
        .ID_W         (ID_W),
        .MAX_WIN_BITS (MAX_WIN_BITS),
        .WB_W         (WB_W)
    ) i_decode (
        .addr         (req_addr),
        .size         (req_size),
        .cfg_win_base (cfg_win_base),
        .cfg_win_bits (cfg_win_bits),
        .cfg_db_addr  (cfg_db_addr),
        .kind         (kind),
        .devid        (dec_devid),
        .eff_bits     (eff_bits)
    );

    assign accept = req_valid && req_ready;
    assign fwd    = accept && ((kind == HIT_DOORBELL) || (kind == HIT_WINDOW));
    assign drop   = accept && ((kind == HIT_NONE) || (kind == HIT_BADFMT));

    msi_out_stage #(
        .DATA_W (DATA_W),
        .ID_W   (ID_W)
    ) i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (fwd),
        .drop       (drop),
        .in_data    (req_data),
        .in_devid   (dec_devid),
        .out_ready  (db_ready),
        .can_accept (req_ready),
        .out_valid  (db_valid),
        .out_data   (db_data),
        .out_devid  (db_devid),
        .err        (req_err)
    );

    p_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |=> db_valid && db_data == $past(req_data))
        else $error("p_data_r3: forwarded data differs");

    p_db_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_addr == cfg_db_addr |=> req_err || db_devid == '0)
        else $error("p_db_zero_r4: direct doorbell write with nonzero ID");

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && kind == HIT_NONE |=> req_err)
        else $error("p_drop_r7: miss not flagged");

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !req_err)
        else $error("p_err_cause_r10: error without accepted write");

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |-> (dec_devid >> eff_bits) == '0)
        else $error("p_range_r2: device ID wider than window");

endmodule

// File: tb/test_msi_devid_bridge.sv
module test_msi_devid_bridge;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int ID_W   = 8;
    localparam int MAXB   = 12;
    localparam int WB_W   = $clog2(MAXB + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_win_base = 32'h8000_0000;
    logic [WB_W-1:0]   cfg_win_bits = WB_W'(4);
    logic [ADDR_W-1:0] cfg_db_addr  = 32'h1000_0040;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [1:0]        req_size = 2'd2;
    logic              req_err;
    logic              db_valid;
    logic              db_ready = 1'b1;
    logic [DATA_W-1:0] db_data;
    logic [ID_W-1:0]   db_devid;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic done   = 1'b0;

    always #10 clk = ~clk;

    msi_devid_bridge #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MAX_WIN_BITS(MAXB), .WB_W(WB_W)
    ) i_msi_devid_bridge (
        .clk(clk), .rst_n(rst_n),
        .cfg_win_base(cfg_win_base), .cfg_win_bits(cfg_win_bits), .cfg_db_addr(cfg_db_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_data(req_data), .req_size(req_size), .req_err(req_err),
        .db_valid(db_valid), .db_ready(db_ready), .db_data(db_data), .db_devid(db_devid)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            finish_run();
        end
    end

    // issue one write with db_ready high; returns outputs sampled after the accept edge
    task automatic issue(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s,
                         output logic v, output logic [31:0] od, output logic [7:0] oid,
                         output logic e, output logic e_next);
        @(negedge clk);
        req_addr  = a;
        req_data  = d;
        req_size  = s;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        v = db_valid; od = db_data; oid = db_devid; e = req_err;
        @(negedge clk);
        e_next = req_err;
    endtask

    task automatic expect_fwd(input string tag, input logic [31:0] a, input logic [31:0] d,
                              input logic [7:0] id);
        logic v, e, en;
        logic [31:0] od;
        logic [7:0] oid;
        issue(a, d, 2'd2, v, od, oid, e, en);
        check(v && !e, {tag, " valid"}, {v, e}, 2'b10);
        check(oid == id, {tag, " devid"}, oid, id);
        check(od == d, {tag, " data R3"}, od, d);
    endtask

    task automatic expect_drop(input string tag, input logic [31:0] a, input logic [1:0] s);
        logic v, e, en;
        logic [31:0] od;
        logic [7:0] oid;
        issue(a, 32'hDEAD_0000 | a, s, v, od, oid, e, en);
        check(!v && e, {tag, " dropped with error"}, {v, e}, 2'b01);
        check(!en, {tag, " R10 error lasts one cycle"}, en, 0);
    endtask

    task automatic t_reset();
        check(!db_valid && !req_err, "R9 reset state", {db_valid, req_err}, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!db_valid && !req_err, "R9 after reset", {db_valid, req_err}, 0);
    endtask

    task automatic t_window();
        expect_fwd("R2 slot 9", 32'h8000_0024, 32'h0000_0011, 8'd9);
        expect_fwd("R2 slot 0", 32'h8000_0000, 32'hFFFF_FFFF, 8'd0);
        expect_fwd("R1 last slot", 32'h8000_003C, 32'h1234_5678, 8'd15);
        expect_drop("R1 past span", 32'h8000_0040, 2'd2);
        expect_drop("R1 below base", 32'h7FFF_FFFC, 2'd2);
    endtask

    task automatic t_doorbell();
        expect_fwd("R4 direct doorbell", 32'h1000_0040, 32'h0000_0077, 8'd0);
        cfg_db_addr = 32'h8000_0010;
        expect_fwd("R4 doorbell beats window", 32'h8000_0010, 32'h0000_0055, 8'd0);
        expect_fwd("R4 neighbour slot", 32'h8000_0014, 32'h0000_0056, 8'd5);
        cfg_db_addr = 32'h1000_0040;
    endtask

    task automatic t_format();
        expect_drop("R6 byte in window", 32'h8000_0008, 2'd0);
        expect_drop("R6 half in window", 32'h8000_0008, 2'd1);
        expect_drop("R6 dword in window", 32'h8000_0008, 2'd3);
        expect_drop("R6 unaligned", 32'h8000_000A, 2'd2);
        expect_drop("R6 byte doorbell", 32'h1000_0040, 2'd0);
        expect_drop("R7 miss", 32'h2000_0000, 2'd2);
    endtask

    task automatic t_narrow();
        cfg_win_bits = WB_W'(10);
        expect_fwd("R5 top narrowed slot", 32'h8000_03FC, 32'h0000_00AB, 8'd255);
        expect_drop("R5 beyond translator width", 32'h8000_0400, 2'd2);
        expect_fwd("R5 mid slot", 32'h8000_0204, 32'h0000_00CD, 8'd129);
        cfg_win_bits = WB_W'(4);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        db_ready  = 1'b0;
        req_addr  = 32'h8000_0008;
        req_data  = 32'hAAAA_0001;
        req_size  = 2'd2;
        req_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h8000_000C;
        req_data = 32'hBBBB_0002;
        check(db_valid && db_devid == 8'd2, "R8 first held", {db_valid, db_devid}, {1'b1, 8'd2});
        check(!req_ready, "R8 ready low when full", req_ready, 0);
        repeat (3) @(negedge clk);
        check(db_valid && db_data == 32'hAAAA_0001, "R8 stable under stall", db_data, 32'hAAAA_0001);
        db_ready = 1'b1;
        #1;
        check(req_ready, "R8 ready when draining", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(db_valid && db_data == 32'hBBBB_0002 && db_devid == 8'd3,
              "R8 second after drain", db_data, 32'hBBBB_0002);
        @(negedge clk);
        check(!db_valid, "R8 drained", db_valid, 0);
    endtask

    initial begin
        t_reset();
        t_window();
        t_doorbell();
        t_format();
        t_narrow();
        t_backpressure();
        done = 1'b1;
        finish_run();
    end

endmodule